// File: doc/BRIEF.md
# Prefetch FIFO drain status and interrupt logger

This block follows a read-prefetch FIFO that a host processor empties byte by byte. The prefetch side reports each burst it writes as a byte count. The host read port pops one byte at a time. A start pulse arms the engine with a transfer count. From then on the block keeps three values: how many bytes sit in the FIFO, how many bytes remain to be requested, and whether the occupancy has reached a programmable threshold.

Two sticky events are logged for software. The first is a FIFO-threshold event. It is recorded once the occupancy reaches the threshold. It can be recorded again only after the host has read the FIFO below the threshold and software has cleared the bit. The second is a terminal-count event. It is recorded when the engine drops by itself from active to inactive after the last byte has been requested. Software clears either bit by writing 1 to it. A per-event enable mask folds both bits into a single interrupt line. A full flag returned to the prefetch side holds off bursts that might not fit.

Top module: `pfd_status`

## Requirements
- R1: After reset, occupancy is 0, remaining count is 0, the engine is inactive, and both status bits, the full flag and the interrupt are 0.
- R2: The 7-bit occupancy rises by the number of bytes accepted from a push and falls by one for each accepted pop. A push and a pop in the same cycle give the net sum.
- R3: A pop while the occupancy is 0 is ignored, and the occupancy stays 0.
- R4: The full flag is high while the occupancy exceeds the depth (64) minus the largest burst (4), that is, at 61 or more. A push while full changes neither the occupancy nor the remaining count.
- R5: The threshold flag is high exactly when the occupancy is greater than or equal to the programmed threshold.
- R6: A start pulse loads the 14-bit remaining count from the transfer count, makes the engine active and clears the occupancy. It leaves both status bits as they were.
- R7: While the engine is active, a push of n bytes (0 to 4) is accepted as min(n, remaining), and the remaining count drops by that amount. Pushes while the engine is inactive are ignored.
- R8: One cycle after the remaining count reaches 0 with the engine active, the engine turns inactive and status bit 1 (terminal count) is set. A start pulse in that cycle takes precedence and no event is logged.
- R9: Status bit 0 (FIFO event) is set one cycle after the occupancy reaches the threshold while the event is armed. Re-arming requires the occupancy to go below the threshold. Clearing the bit while the FIFO is still at or above the threshold does not log it again.
- R10: Writing 1 to a bit of the clear input clears that status bit and leaves the other bit unchanged. When a set condition and a clear fall in the same cycle, the bit ends up set.
- R11: The interrupt equals (status[0] AND enable[0]) OR (status[1] AND enable[1]).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Engine start pulse |
| xfer_cnt_i | input | 14 | Bytes to request in this transfer |
| thresh_i | input | 7 | FIFO threshold in bytes |
| push_i | input | 1 | Prefetch side writes a burst |
| push_bytes_i | input | 3 | Bytes in the burst (0 to 4) |
| pop_i | input | 1 | Host reads one byte |
| clr_i | input | 2 | Write-1-to-clear strobe per status bit |
| irq_en_i | input | 2 | Interrupt enable per status bit |
| occ_o | output | 7 | Bytes available to read |
| full_o | output | 1 | No room for a maximal burst |
| thr_o | output | 1 | Occupancy at or above threshold |
| remain_o | output | 14 | Bytes still to be requested |
| active_o | output | 1 | Engine active |
| sts_o | output | 2 | Sticky status: bit 0 FIFO event, bit 1 terminal count |
| irq_o | output | 1 | Interrupt line |

## Verification
The hardest case to reach is re-logging the FIFO event. The stimulus must first log the event, then clear it while the FIFO is still above the threshold and confirm that nothing is logged again. Next it drains the FIFO below the threshold after the engine has stopped, waits one idle cycle so the arm can recover, and lowers the threshold to meet the remaining occupancy. A second hard case is a clear strobe that arrives in the very cycle the engine terminates. The bench reaches it with a zero transfer count, which makes termination fall exactly one cycle after the start.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    localparam int DEF_DEPTH    = 64;
    localparam int DEF_PUSH_MAX = 4;
    localparam int DEF_CNT_W    = 14;

    typedef struct packed {
        logic tc;
        logic fifo;
    } ev_t;

    function automatic int full_limit(int depth, int push_max);
        return depth - push_max;
    endfunction

endpackage

// File: rtl/pfd_occupancy.sv
module pfd_occupancy #(
    parameter int DEPTH    = pfd_pkg::DEF_DEPTH,
    parameter int PUSH_MAX = pfd_pkg::DEF_PUSH_MAX,
    parameter int PUSH_W   = $clog2(PUSH_MAX + 1),
    parameter int OCC_W    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear_i,
    input  logic [PUSH_W-1:0] add_i,
    input  logic              pop_i,
    output logic [OCC_W-1:0]  occ_o,
    output logic              full_o
);
    localparam int LIMIT = pfd_pkg::full_limit(DEPTH, PUSH_MAX);

    logic [OCC_W-1:0] occ_q;
    logic             pop_ok;

    assign pop_ok = pop_i && (occ_q != '0);
    assign full_o = occ_q > OCC_W'(LIMIT);
    assign occ_o  = occ_q;

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            occ_q <= '0;
        end else begin
            occ_q <= occ_q + OCC_W'(add_i) - OCC_W'(pop_ok);
        end
    end
endmodule

// File: rtl/pfd_engine.sv
module pfd_engine #(
    parameter int CNT_W  = pfd_pkg::DEF_CNT_W,
    parameter int PUSH_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [CNT_W-1:0]  load_i,
    input  logic              push_i,
    input  logic [PUSH_W-1:0] push_bytes_i,
    input  logic              full_i,
    output logic [PUSH_W-1:0] accept_o,
    output logic [CNT_W-1:0]  remain_o,
    output logic              active_o,
    output logic              tc_evt_o
);
    logic [CNT_W-1:0] remain_q;
    logic             active_q;
    logic [CNT_W-1:0] bytes_ext;

    assign bytes_ext = CNT_W'(push_bytes_i);

    always_comb begin
        accept_o = '0;
        if (push_i && active_q && !full_i && !start_i) begin
            accept_o = (bytes_ext <= remain_q) ? push_bytes_i : PUSH_W'(remain_q);
        end
    end

    assign tc_evt_o = active_q && (remain_q == '0) && !start_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain_q <= '0;
            active_q <= 1'b0;
        end else if (start_i) begin
            remain_q <= load_i;
            active_q <= 1'b1;
        end else begin
            remain_q <= remain_q - CNT_W'(accept_o);
            if (tc_evt_o) begin
                active_q <= 1'b0;
            end
        end
    end

    assign remain_o = remain_q;
    assign active_o = active_q;
endmodule

// File: rtl/pfd_event_log.sv
module pfd_event_log #(
    parameter int OCC_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [OCC_W-1:0] occ_i,
    input  logic [OCC_W-1:0] thresh_i,
    input  logic             tc_evt_i,
    input  logic [1:0]       clr_i,
    input  logic [1:0]       irq_en_i,
    output logic             thr_o,
    output logic [1:0]       sts_o,
    output logic             irq_o
);
    import pfd_pkg::*;

    ev_t  sts_q, set_v, clr_v, en_v;
    logic arm_q;

    assign thr_o      = occ_i >= thresh_i;
    assign set_v.fifo = thr_o && arm_q;
    assign set_v.tc   = tc_evt_i;
    assign clr_v      = ev_t'(clr_i);
    assign en_v       = ev_t'(irq_en_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            arm_q <= 1'b1;
        end else if (set_v.fifo) begin
            arm_q <= 1'b0;
        end else if (!thr_o) begin
            arm_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sts_q <= '0;
        end else begin
            sts_q <= (sts_q & ~clr_v) | set_v;
        end
    end

    assign sts_o = sts_q;
    assign irq_o = |(sts_q & en_v);
endmodule

// File: rtl/pfd_status.sv
module pfd_status #(
    parameter int DEPTH    = pfd_pkg::DEF_DEPTH,
    parameter int PUSH_MAX = pfd_pkg::DEF_PUSH_MAX,
    parameter int CNT_W    = pfd_pkg::DEF_CNT_W,
    parameter int PUSH_W   = $clog2(PUSH_MAX + 1),
    parameter int OCC_W    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [CNT_W-1:0]  xfer_cnt_i,
    input  logic [OCC_W-1:0]  thresh_i,
    input  logic              push_i,
    input  logic [PUSH_W-1:0] push_bytes_i,
    input  logic              pop_i,
    input  logic [1:0]        clr_i,
    input  logic [1:0]        irq_en_i,
    output logic [OCC_W-1:0]  occ_o,
    output logic              full_o,
    output logic              thr_o,
    output logic [CNT_W-1:0]  remain_o,
    output logic              active_o,
    output logic [1:0]        sts_o,
    output logic              irq_o
);
    logic [PUSH_W-1:0] accept;
    logic              tc_evt;

    pfd_engine #(
        .CNT_W (CNT_W),
        .PUSH_W(PUSH_W)
    ) u_engine (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .load_i      (xfer_cnt_i),
        .push_i      (push_i),
        .push_bytes_i(push_bytes_i),
        .full_i      (full_o),
        .accept_o    (accept),
        .remain_o    (remain_o),
        .active_o    (active_o),
        .tc_evt_o    (tc_evt)
    );

    pfd_occupancy #(
        .DEPTH   (DEPTH),
        .PUSH_MAX(PUSH_MAX),
        .PUSH_W  (PUSH_W),
        .OCC_W   (OCC_W)
    ) u_occ (
        .clk    (clk),
        .rst    (rst),
        .clear_i(start_i),
        .add_i  (accept),
        .pop_i  (pop_i),
        .occ_o  (occ_o),
        .full_o (full_o)
    );

    pfd_event_log #(
        .OCC_W(OCC_W)
    ) u_log (
        .clk     (clk),
        .rst     (rst),
        .occ_i   (occ_o),
        .thresh_i(thresh_i),
        .tc_evt_i(tc_evt),
        .clr_i   (clr_i),
        .irq_en_i(irq_en_i),
        .thr_o   (thr_o),
        .sts_o   (sts_o),
        .irq_o   (irq_o)
    );
endmodule

// File: rtl/pfd_status_chk.sv
module pfd_status_chk #(
    parameter int DEPTH  = 64,
    parameter int CNT_W  = 14,
    parameter int PUSH_W = 3,
    parameter int OCC_W  = 7
) (
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic [CNT_W-1:0]  xfer_cnt_i,
    input logic              push_i,
    input logic [PUSH_W-1:0] push_bytes_i,
    input logic              pop_i,
    input logic [1:0]        clr_i,
    input logic [OCC_W-1:0]  occ_o,
    input logic              full_o,
    input logic [CNT_W-1:0]  remain_o,
    input logic              active_o,
    input logic [1:0]        sts_o,
    input logic              irq_o
);
    assert_occ_bound_R2: assert property (@(posedge clk) disable iff (rst)
        occ_o <= OCC_W'(DEPTH));

    assert_pop_empty_R3: assert property (@(posedge clk) disable iff (rst)
        (occ_o == '0 && pop_i && !push_i && !start_i) |=> occ_o == '0);

    assert_full_block_R4: assert property (@(posedge clk) disable iff (rst)
        (full_o && !start_i) |=> occ_o <= $past(occ_o));

    assert_start_load_R6: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (active_o && occ_o == '0 && remain_o == $past(xfer_cnt_i)));

    assert_remain_down_R7: assert property (@(posedge clk) disable iff (rst)
        !start_i |=> remain_o <= $past(remain_o));

    assert_tc_on_fall_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(active_o) |-> sts_o[1]);

    assert_tc_only_fall_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(sts_o[1]) |-> $fell(active_o));

    assert_fifo_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (sts_o[0] && !clr_i[0]) |=> sts_o[0]);

    assert_tc_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (sts_o[1] && !clr_i[1]) |=> sts_o[1]);

    assert_irq_source_R11: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (sts_o != 2'b00));
endmodule

bind pfd_status pfd_status_chk #(
    .DEPTH (DEPTH),
    .CNT_W (CNT_W),
    .PUSH_W(PUSH_W),
    .OCC_W (OCC_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .xfer_cnt_i  (xfer_cnt_i),
    .push_i      (push_i),
    .push_bytes_i(push_bytes_i),
    .pop_i       (pop_i),
    .clr_i       (clr_i),
    .occ_o       (occ_o),
    .full_o      (full_o),
    .remain_o    (remain_o),
    .active_o    (active_o),
    .sts_o       (sts_o),
    .irq_o       (irq_o)
);

// File: tb/pfd_status_tb.sv
`timescale 1ns/1ps
module pfd_status_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [13:0] xfer_cnt_i = '0;
    logic [6:0]  thresh_i = 7'd8;
    logic        push_i = 1'b0;
    logic [2:0]  push_bytes_i = '0;
    logic        pop_i = 1'b0;
    logic [1:0]  clr_i = '0;
    logic [1:0]  irq_en_i = '0;
    logic [6:0]  occ_o;
    logic        full_o;
    logic        thr_o;
    logic [13:0] remain_o;
    logic        active_o;
    logic [1:0]  sts_o;
    logic        irq_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    pfd_status u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .xfer_cnt_i(xfer_cnt_i),
        .thresh_i(thresh_i), .push_i(push_i), .push_bytes_i(push_bytes_i),
        .pop_i(pop_i), .clr_i(clr_i), .irq_en_i(irq_en_i), .occ_o(occ_o),
        .full_o(full_o), .thr_o(thr_o), .remain_o(remain_o), .active_o(active_o),
        .sts_o(sts_o), .irq_o(irq_o)
    );

    task automatic check(string req, string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic push(int n);
        push_i = 1'b1;
        push_bytes_i = 3'(n);
        cyc();
        push_i = 1'b0;
        push_bytes_i = '0;
    endtask

    task automatic start(int cnt);
        xfer_cnt_i = 14'(cnt);
        start_i = 1'b1;
        cyc();
        start_i = 1'b0;
    endtask

    task automatic t_reset();
        check("R1", "occ", occ_o, 0);
        check("R1", "remain", remain_o, 0);
        check("R1", "active", active_o, 0);
        check("R1", "sts", sts_o, 0);
        check("R1", "irq", irq_o, 0);
        check("R1", "full", full_o, 0);
    endtask

    task automatic t_fill_and_finish();
        start(10);
        check("R6", "remain load", remain_o, 10);
        check("R6", "active", active_o, 1);
        check("R6", "occ cleared", occ_o, 0);
        push(4);
        check("R2", "occ after push", occ_o, 4);
        check("R7", "remain after push", remain_o, 6);
        push(4);
        check("R5", "thr at 8", thr_o, 1);
        check("R9", "sts not yet", sts_o, 0);
        cyc();
        check("R9", "fifo event", sts_o, 1);
        push(4);
        check("R7", "clamped occ", occ_o, 10);
        check("R7", "remain zero", remain_o, 0);
        check("R8", "still active", active_o, 1);
        cyc();
        check("R8", "inactive", active_o, 0);
        check("R8", "tc event", sts_o, 3);
        irq_en_i = 2'b00; #1;
        check("R11", "irq masked", irq_o, 0);
        irq_en_i = 2'b10; #1;
        check("R11", "irq tc", irq_o, 1);
        irq_en_i = 2'b00;
    endtask

    task automatic t_rearm();
        clr_i = 2'b01;
        cyc();
        clr_i = 2'b00;
        check("R10", "fifo cleared", sts_o, 2);
        cyc();
        check("R9", "no relog above thr", sts_o, 2);
        push(4);
        check("R7", "push inactive ignored", occ_o, 10);
        pop_i = 1'b1;
        cyc(); cyc(); cyc();
        pop_i = 1'b0;
        check("R2", "after pops", occ_o, 7);
        check("R5", "thr below", thr_o, 0);
        cyc();
        thresh_i = 7'd7;
        cyc();
        check("R9", "relog after rearm", sts_o, 3);
        irq_en_i = 2'b01; #1;
        check("R11", "irq fifo", irq_o, 1);
        irq_en_i = 2'b00;
    endtask

    task automatic t_start_keep_and_clear();
        start(0);
        check("R6", "active zero cnt", active_o, 1);
        check("R6", "occ cleared", occ_o, 0);
        check("R6", "sts kept", sts_o, 3);
        clr_i = 2'b10;
        cyc();
        clr_i = 2'b00;
        check("R8", "zero cnt terminates", active_o, 0);
        check("R10", "set wins over clear", sts_o, 3);
        clr_i = 2'b10;
        cyc();
        clr_i = 2'b00;
        check("R10", "tc cleared only", sts_o, 1);
        irq_en_i = 2'b10; #1;
        check("R11", "irq tc cleared", irq_o, 0);
        irq_en_i = 2'b00;
        pop_i = 1'b1;
        cyc();
        pop_i = 1'b0;
        check("R3", "pop empty", occ_o, 0);
    endtask

    task automatic t_full();
        thresh_i = 7'd100;
        start(100);
        for (int i = 0; i < 15; i++) push(4);
        check("R4", "occ 60", occ_o, 60);
        check("R4", "not full at 60", full_o, 0);
        push(4);
        check("R4", "occ 64", occ_o, 64);
        check("R4", "full at 64", full_o, 1);
        push(4);
        check("R4", "blocked occ", occ_o, 64);
        check("R4", "blocked remain", remain_o, 36);
        pop_i = 1'b1;
        push(4);
        push(4);
        pop_i = 1'b0;
        check("R4", "pop while full", occ_o, 62);
        check("R4", "remain unchanged", remain_o, 36);
        pop_i = 1'b1;
        cyc(); cyc();
        check("R4", "full cleared", full_o, 0);
        push(3);
        pop_i = 1'b0;
        check("R2", "push and pop net", occ_o, 62);
        check("R7", "remain after 3", remain_o, 33);
        thresh_i = 7'd62; #1;
        check("R5", "thr equal", thr_o, 1);
        thresh_i = 7'd63; #1;
        check("R5", "thr above", thr_o, 0);
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) cyc();
        rst = 1'b0;
        cyc();
        t_reset();
        t_fill_and_finish();
        t_rearm();
        t_start_keep_and_clear();
        t_full();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule